// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger Level and Idle Timeout

This block buffers received bytes for a 16550-style serial port. A deserializer hands it one byte at a time through a push strobe, or signals a line break through a separate strobe; the host drains the queue through a read strobe. The queue is sixteen bytes deep and keeps the receive status that goes with it: data-ready, break, overrun, a trigger-reached flag and a character-timeout flag.

The host steers the queue through an 8-bit control register. The control register sets the interrupt trigger level and the enable bit, and it can request flushes of the receive queue and of the (external) transmit queue. A character-time tick from the baud logic drives an idle timer. The timer raises the timeout flag when the queue has held data for four character times with no push and no read.

Top module: `uart_rxq`

## Requirements
- R1: After reset the level is 0, the control value is 0x00, and data-ready, break, overrun, timeout-pending, trigger-reached, transmit-flush and read data are all 0.
- R2: The queue returns bytes in arrival order and holds up to 16. A read of an empty queue returns 0x00 and leaves the level unchanged. Read data appears after the clock edge that samples the read strobe.
- R3: A push or break into a full queue, with no read in the same cycle, discards the byte and sets overrun. A line-status read strobe clears overrun and break. A set in the same cycle wins over that clear.
- R4: While control bit 0 (enable) is 1, trigger-reached is level >= threshold. Control bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. While enable is 0, trigger-reached means the queue is not empty.
- R5: A control write with bit 1 set empties the receive queue and clears data-ready, break and timeout-pending. With bit 2 set, the write raises the transmit-flush output for exactly the following cycle. The register keeps only the bits under mask 0xC9.
- R6: A control write that changes bit 0 acts as if bits 1 and 2 were both set.
- R7: A control write whose value equals the current control value has no effect.
- R8: Every push sets data-ready. A read that leaves the queue empty clears data-ready and break. Data-ready is 1 whenever the level is nonzero.
- R9: Each push or break, and each read that leaves data behind, restarts a four-tick idle timer. The fourth character tick after the restart sets timeout-pending when the queue holds data.
- R10: Any read clears timeout-pending. An expiry with an empty queue does not set it. A read that empties the queue stops the timer.
- R11: A break strobe pushes a 0x00 byte and sets both break and data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_push | input | 1 | Push rx_byte into the queue |
| rx_break | input | 1 | Break detected; pushes a zero byte |
| rd_en | input | 1 | Host read of the oldest byte |
| rd_data | output | 8 | Byte returned by the last read |
| lsr_rd | input | 1 | Host read of line status; clears overrun and break |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_value | output | 8 | Retained control register value |
| tx_clr | output | 1 | One-cycle transmit-queue flush request |
| char_tick | input | 1 | One pulse per character time |
| level | output | 5 | Bytes held in the queue |
| data_ready | output | 1 | Receive data available |
| brk | output | 1 | Break received |
| overrun | output | 1 | Byte lost to a full queue |
| trig_hit | output | 1 | Level has reached the trigger threshold |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
Every registered result is due one clock edge after the strobe that causes it: level, status bits, read data, control value and the transmit-flush pulse. Trigger-reached follows combinationally from the registered level and control value in the same cycle. The timeout flag appears after the edge that samples the fourth tick. The bench drives strobes on falling edges and compares every output against its queue-based model at the next falling edge. Each comparison therefore sees exactly one rising edge's worth of effect. Directed checks of fixed values are placed at the same sampling point.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;
    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_RXCLR_BIT = 1;
    localparam int unsigned CTL_TXCLR_BIT = 2;

    // threshold for the 2-bit trigger select, scaled to the queue depth
    function automatic int unsigned trig_threshold(input logic [1:0] sel,
                                                   input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [W-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_inc, rp_inc;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wp_inc = ptr_q.wp + 1'b1;
            assign rp_inc = ptr_q.rp + 1'b1;
        end else begin : g_cmp_wrap
            assign wp_inc = (ptr_q.wp == AW'(DEPTH - 1)) ? '0 : ptr_q.wp + 1'b1;
            assign rp_inc = (ptr_q.rp == AW'(DEPTH - 1)) ? '0 : ptr_q.rp + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            if (push) ptr_d.wp = wp_inc;
            if (pop)  ptr_d.rp = rp_inc;
            ptr_d.lvl = ptr_q.lvl + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[ptr_q.wp] <= wdata;
    end

    assign head  = mem_q[ptr_q.rp];
    assign level = ptr_q.lvl;

    // R2: occupancy never exceeds the depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.lvl <= LW'(DEPTH));

endmodule

// File: rtl/uart_rxq_tmo.sv
module uart_rxq_tmo #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmo_t;

    tmo_t tmo_q, tmo_d;

    always_comb begin
        tmo_d  = tmo_q;
        expire = 1'b0;
        if (restart) begin
            tmo_d.run = 1'b1;
            tmo_d.cnt = '0;
        end else if (stop) begin
            tmo_d.run = 1'b0;
        end else if (tick && tmo_q.run) begin
            tmo_d.cnt = tmo_q.cnt + 1'b1;
            if (tmo_q.cnt == CW'(LIMIT - 1)) begin
                tmo_d.run = 1'b0;
                expire    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmo_q <= '0;
        else        tmo_q <= tmo_d;
    end

    // R9: the count saturates at the limit and the timer is idle there
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q.cnt <= CW'(LIMIT));
    p_idle_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_q.cnt == CW'(LIMIT)) |-> !tmo_q.run);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned TMO_CHARS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_push,
    input  logic                   rx_break,
    input  logic                   rd_en,
    output logic [7:0]             rd_data,
    input  logic                   lsr_rd,
    input  logic                   ctl_wr,
    input  logic [7:0]             ctl_wdata,
    output logic [7:0]             ctl_value,
    output logic                   tx_clr,
    input  logic                   char_tick,
    output logic [$clog2(DEPTH):0] level,
    output logic                   data_ready,
    output logic                   brk,
    output logic                   overrun,
    output logic                   trig_hit,
    output logic                   tmo_pend
);
    import uart_rxq_pkg::*;

    localparam int unsigned LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] rdata;
        logic       dr;
        logic       brk;
        logic       ovr;
        logic       pend;
        logic       txclr;
    } st_t;

    st_t st_q, st_d;

    logic [7:0]    head;
    logic [LW-1:0] lvl;
    logic [LW-1:0] thr;
    logic [7:0]    wv;
    logic          wr_take, rx_clear, tx_clear;
    logic          pop, push_req, push_ok, last_pop;
    logic          tmo_restart, tmo_stop, tmo_expire;

    always_comb begin
        wr_take  = ctl_wr && (ctl_wdata != st_q.ctl);
        wv       = ctl_wdata |
                   ((ctl_wdata[CTL_EN_BIT] != st_q.ctl[CTL_EN_BIT]) ? 8'h06 : 8'h00);
        rx_clear = wr_take && wv[CTL_RXCLR_BIT];
        tx_clear = wr_take && wv[CTL_TXCLR_BIT];
        pop      = rd_en && !rx_clear && (lvl != '0);
        push_req = (rx_push || rx_break) && !rx_clear;
        push_ok  = push_req && ((lvl != LW'(DEPTH)) || pop);
        last_pop = pop && (lvl == LW'(1)) && !push_req;
        tmo_restart = push_req || (pop && !last_pop);
        tmo_stop    = rx_clear || last_pop;
    end

    always_comb begin
        st_d       = st_q;
        st_d.txclr = tx_clear;
        if (wr_take) st_d.ctl = wv & CTL_KEEP_MASK;
        if (rd_en) begin
            st_d.rdata = pop ? head : 8'h00;
            st_d.pend  = 1'b0;
        end
        if (lsr_rd) begin
            st_d.ovr = 1'b0;
            st_d.brk = 1'b0;
        end
        if (rx_clear) begin
            st_d.dr   = 1'b0;
            st_d.brk  = 1'b0;
            st_d.pend = 1'b0;
        end else begin
            if (push_req) begin
                st_d.dr = 1'b1;
                if (rx_break) st_d.brk = 1'b1;
                if (!push_ok) st_d.ovr = 1'b1;
            end
            if (last_pop) begin
                st_d.dr  = 1'b0;
                st_d.brk = 1'b0;
            end
            if (tmo_expire && (lvl != '0)) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_rxq_mem #(.DEPTH(DEPTH), .W(8)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clear),
        .push  (push_ok),
        .pop   (pop),
        .wdata (rx_break ? 8'h00 : rx_byte),
        .head  (head),
        .level (lvl)
    );

    uart_rxq_tmo #(.LIMIT(TMO_CHARS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmo_restart),
        .stop    (tmo_stop),
        .tick    (char_tick),
        .expire  (tmo_expire)
    );

    assign thr        = LW'(trig_threshold(st_q.ctl[7:6], DEPTH));
    assign trig_hit   = st_q.ctl[CTL_EN_BIT] ? (lvl >= thr) : (lvl != '0);
    assign level      = lvl;
    assign rd_data    = st_q.rdata;
    assign ctl_value  = st_q.ctl;
    assign tx_clr     = st_q.txclr;
    assign data_ready = st_q.dr;
    assign brk        = st_q.brk;
    assign overrun    = st_q.ovr;
    assign tmo_pend   = st_q.pend;

    p_dr_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0) |-> data_ready);

    p_pend_with_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pend |-> (level != '0));

    p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0 && !rx_push && !rx_break) |=> (rd_data == 8'h00 && level == '0));

    p_full_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_push || rx_break) && level == LW'(DEPTH) && !rd_en && !ctl_wr)
        |=> (overrun && level == LW'(DEPTH)));

    p_keep_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_value & ~CTL_KEEP_MASK) == 8'h00);

    p_toggle_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[0] != ctl_value[0]) |=> (tx_clr && level == '0));

    p_same_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata == ctl_value) |=> ($stable(ctl_value) && !tx_clr));

    p_break_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !ctl_wr) |=> (brk && data_ready));

endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_push = 1'b0, rx_break = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0;
    logic       ctl_wr = 1'b0, char_tick = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] rd_data, ctl_value;
    logic [4:0] level;
    logic       tx_clr, data_ready, brk, overrun, trig_hit, tmo_pend;

    always #5 clk = ~clk;

    uart_rxq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_push(rx_push),
        .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_value(ctl_value),
        .tx_clr(tx_clr), .char_tick(char_tick), .level(level),
        .data_ready(data_ready), .brk(brk), .overrun(overrun),
        .trig_hit(trig_hit), .tmo_pend(tmo_pend)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model
    byte unsigned mq[$];
    logic [7:0] m_ctl, m_rd;
    bit m_dr, m_brk, m_ovr, m_pend, m_tx, m_run;
    int m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ctl = 0; m_rd = 0; m_dr = 0; m_brk = 0; m_ovr = 0;
            m_pend = 0; m_tx = 0; m_run = 0; m_cnt = 0;
        end else begin
            logic [7:0] v;
            bit rxclr, pop, preq, restart, stop;
            rxclr = 0; m_tx = 0;
            if (ctl_wr && ctl_wdata != m_ctl) begin
                v = ctl_wdata;
                if (v[0] != m_ctl[0]) v = v | 8'h06;
                rxclr = v[1];
                m_tx  = v[2];
                m_ctl = v & 8'hC9;
            end
            if (lsr_rd) begin m_ovr = 0; m_brk = 0; end
            if (rxclr) begin
                mq.delete();
                m_dr = 0; m_brk = 0; m_pend = 0; m_run = 0;
                if (rd_en) m_rd = 0;
            end else begin
                pop  = rd_en && mq.size() > 0;
                preq = rx_push || rx_break;
                if (rd_en) begin
                    m_rd = pop ? mq.pop_front() : 8'h00;
                    m_pend = 0;
                end
                if (preq) begin
                    if (mq.size() >= 16) m_ovr = 1;
                    else mq.push_back(rx_break ? 8'h00 : rx_byte);
                    m_dr = 1;
                    if (rx_break) m_brk = 1;
                end else if (pop && mq.size() == 0) begin
                    m_dr = 0; m_brk = 0;
                end
                restart = preq || (pop && mq.size() > 0);
                stop    = pop && mq.size() == 0 && !preq;
                if (restart) begin m_run = 1; m_cnt = 0; end
                else if (stop) m_run = 0;
                else if (char_tick && m_run) begin
                    m_cnt++;
                    if (m_cnt == 4) begin
                        m_run = 0;
                        if (mq.size() > 0) m_pend = 1;
                    end
                end
            end
        end
    end

    function automatic bit m_trig();
        int thr;
        case (m_ctl[7:6])
            2'b00: thr = 1;
            2'b01: thr = 4;
            2'b10: thr = 8;
            default: thr = 14;
        endcase
        return m_ctl[0] ? (mq.size() >= thr) : (mq.size() > 0);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2",  "level",      level,      mq.size());
        chk("R2",  "rd_data",    rd_data,    m_rd);
        chk("R8",  "data_ready", data_ready, m_dr);
        chk("R11", "brk",        brk,        m_brk);
        chk("R3",  "overrun",    overrun,    m_ovr);
        chk("R4",  "trig_hit",   trig_hit,   m_trig());
        chk("R9",  "tmo_pend",   tmo_pend,   m_pend);
        chk("R5",  "ctl_value",  ctl_value,  m_ctl);
        chk("R5",  "tx_clr",     tx_clr,     m_tx);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        rx_push = 0; rx_break = 0; rd_en = 0; lsr_rd = 0; ctl_wr = 0; char_tick = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_byte = b; rx_push = 1; cyc();
    endtask
    task automatic rd();
        rd_en = 1; cyc();
    endtask
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin char_tick = 1; cyc(); end
    endtask
    task automatic wctl(input logic [7:0] v);
        ctl_wdata = v; ctl_wr = 1; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "level", level, 0);
        chk("R1", "ctl_value", ctl_value, 0);
        chk("R1", "status", {data_ready, brk, overrun, tmo_pend, trig_hit, tx_clr}, 0);
        chk("R1", "rd_data", rd_data, 0);

        wctl(8'h01);
        chk("R6", "tx_clr on enable toggle", tx_clr, 1);

        push(8'h11); push(8'h22); push(8'h33);
        rd();
        chk("R2", "first byte", rd_data, 8'h11);
        tick(3);
        chk("R9", "pend before 4th tick", tmo_pend, 0);
        tick(1);
        chk("R9", "pend at 4th tick", tmo_pend, 1);
        rd();
        chk("R10", "read clears pend", tmo_pend, 0);
        push(8'h44);
        tick(2);
        rd();
        tick(3);
        chk("R9", "read restarts timer", tmo_pend, 0);
        tick(1);
        chk("R9", "pend after restart", tmo_pend, 1);
        rd(); rd();
        chk("R8", "empty clears ready", data_ready, 0);
        tick(5);
        chk("R10", "no pend when empty", tmo_pend, 0);

        for (int i = 0; i < 16; i++) push(8'(8'hA0 + i));
        push(8'hEE);
        chk("R3", "overrun on full", overrun, 1);
        chk("R3", "level stays full", level, 16);
        lsr_rd = 1; cyc();
        chk("R3", "lsr read clears overrun", overrun, 0);

        wctl(8'h41);
        chk("R4", "trig at 4", trig_hit, 1);
        wctl(8'hC1);
        rd(); rd(); rd();
        chk("R4", "13 below 14", trig_hit, 0);
        wctl(8'hC1);
        chk("R7", "same write no flush", tx_clr, 0);
        chk("R7", "same write keeps level", level, 13);
        wctl(8'hC3);
        chk("R5", "rx clear empties", level, 0);
        chk("R5", "rx clear keeps ctl", ctl_value, 8'hC1);
        rd();
        chk("R2", "empty read returns zero", rd_data, 0);

        rx_break = 1; cyc();
        chk("R11", "break level", level, 1);
        chk("R11", "break bit", brk, 1);
        rd();
        chk("R11", "break byte is zero", rd_data, 0);
        chk("R8", "break cleared on empty", brk, 0);

        wctl(8'h00);
        chk("R6", "disable toggle flush", tx_clr, 1);
        push(8'h55);
        chk("R4", "disabled trig on nonempty", trig_hit, 1);
        wctl(8'hCF);
        chk("R5", "mask C9", ctl_value, 8'hC9);
        chk("R6", "toggle empties", level, 0);

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            rx_byte   = 8'($urandom);
            rx_push   = (r % 3) == 0;
            rx_break  = (r % 41) == 0;
            rd_en     = ((r / 7) % 4) == 0;
            lsr_rd    = ((r / 11) % 17) == 0;
            char_tick = ((r / 13) % 3) == 0;
            if (((r / 17) % 97) == 0) begin
                int k;
                k = (r / 1000) % 6;
                ctl_wr = 1;
                case (k)
                    0: ctl_wdata = 8'h01;
                    1: ctl_wdata = 8'h41;
                    2: ctl_wdata = 8'h81;
                    3: ctl_wdata = 8'hC3;
                    4: ctl_wdata = 8'h00;
                    default: ctl_wdata = 8'hC5;
                endcase
            end
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule